// File: doc/BRIEF.md
# Magnetometer Result Register and Ready Controller

This block holds the three 16-bit axis results of a magnetometer-style sensor as six readable bytes. It decides when fresh results from the measurement engine may replace them. It keeps the status flags for ready, lock and overwritten, and drives an active-low data-ready pin. It also schedules measurement start pulses, either one at a time or continuously at a selectable output rate. The serial bus front end sits outside the block. It reports register writes, pointer loads and completed reads. It reads back the byte selected by the block's auto-incrementing register pointer.

Two state machines do the work. The scheduler has four states. SC_ONE_GO issues one start and moves to SC_ONE_WAIT. SC_ONE_WAIT waits for the engine; on "engine done" it goes to SC_IDLE and rewrites the mode field to idle. SC_CONT counts the output period and starts a measurement whenever the count expires. A mode write takes the "mode write" transition from any state to the state that the new mode field selects. The poster has two states. In PB_IDLE it waits for an unlocked result. On "accept" it moves to PB_HOLD, where ready stays low for the minimum gap. On "commit" it returns to PB_IDLE, writes the result bytes, raises ready and starts the data-ready pulse.

All minimum widths and periods come from a clock-frequency parameter. HOLD is CLK_HZ/5000+1 cycles, which is just over 200 µs. P(code) is CLK_HZ divided by the rate in Hz. The rate codes 0 to 7 select 0.75, 1.5, 3, 7.5, 15, 30, 75 and 220 Hz.

Top module: `magres_ctrl`

## Requirements
- R1: After reset the first configuration register (address 0x00) reads 0x10, the mode register (0x02) reads 0x01, status reads 0x00, drdy_n is 1 and the pointer is 0x00. One start pulse is issued in the first cycle after reset.
- R2: The result bytes are placed as follows: 0x03 holds X high and 0x04 holds X low; 0x05 holds Z high and 0x06 holds Z low; 0x07 holds Y high and 0x08 holds Y low. Status is at 0x09, with bit 0 = ready, bit 1 = lock and bit 2 = overwritten. Unused addresses read 0.
- R3: ptr_load sets the pointer. Each rd_ack moves it up by one, except that an acknowledged read at 0x08 sends it back to 0x03.
- R4: An acknowledged read of any result byte sets lock, and so does an acknowledged read of the mode register. While lock is set, a meas_done result is discarded: the bytes, ready and drdy_n do not change.
- R5: Lock clears on any write to the mode register or to the first configuration register. It also clears on a start pulse that comes after all six result bytes have been read.
- R6: After an accepted result, ready is 0 for exactly HOLD cycles. The new bytes then appear in the same cycle that ready returns to 1.
- R7: drdy_n goes low in the cycle the new bytes appear and stays low for exactly HOLD cycles.
- R8: Overwritten is set when a result is committed while the previous result has not been fully read. Any acknowledged result-byte read clears it.
- R9: Writing mode field 01 (bits 1:0) issues exactly one start. When that measurement completes, the mode field becomes 10 (idle). Field values 10 and 11 issue no starts.
- R10: Writing mode field 00 gives a first start 2·P cycles after the write edge and later starts every P cycles, where P comes from bits 4:2 of the first configuration register.
- R11: A write to the first configuration register in continuous mode restarts the 2·P wait from that write.
- R12: Mode bit 5 (low power) forces rate_eff to 0 and avg_eff to 0. Without it, they follow bits 4:2 and 6:5 of the first configuration register.
- R13: Writes to addresses 0x03–0x09 are ignored, and so are writes to mode bits 6, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| ptr_load | input | 1 | Load the register pointer |
| ptr_val | input | 8 | New pointer value |
| rd_ack | input | 1 | Read at the pointer completed |
| rd_data | output | 8 | Byte at the pointer |
| reg_ptr | output | 8 | Current pointer |
| meas_start | output | 1 | Start one measurement |
| meas_done | input | 1 | Engine result valid |
| x_in | input | 16 | X result |
| y_in | input | 16 | Y result |
| z_in | input | 16 | Z result |
| drdy_n | output | 1 | Active-low data-ready pin |
| cfg_a | output | 8 | First configuration register |
| mode_r | output | 8 | Mode register |
| rate_eff | output | 3 | Effective rate code |
| avg_eff | output | 2 | Effective averaging code |

## Verification
The hardest case to reach is a lock released by a start pulse. Every write to a register clears lock on its own, so this release can only be shown in continuous mode with no writes in between. The stimulus first switches to continuous at the fastest rate and waits for the first start. It then posts a result and reads all six bytes in the gap before the next start. Finally it checks the status after that start, with no write on the bus.

// File: rtl/magres_pkg.sv
package magres_pkg;

    typedef enum logic [1:0] {
        SC_IDLE     = 2'd0,
        SC_ONE_GO   = 2'd1,
        SC_ONE_WAIT = 2'd2,
        SC_CONT     = 2'd3
    } sched_st_e;

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_HOLD = 1'b1
    } post_st_e;

    localparam logic [1:0] MD_CONT = 2'b00;
    localparam logic [1:0] MD_ONE  = 2'b01;
    localparam logic [1:0] MD_IDLE = 2'b10;

    localparam logic [7:0] A_CFG    = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h02;
    localparam logic [7:0] A_RES_LO = 8'h03;
    localparam logic [7:0] A_RES_HI = 8'h08;
    localparam logic [7:0] A_STAT   = 8'h09;

    localparam logic [7:0] CFG_RST    = 8'h10;
    localparam logic [7:0] MODE_RST   = 8'h01;
    localparam logic [7:0] MODE_WMASK = 8'hA7;
    localparam int         LP_BIT     = 5;
    localparam int         NBYTES     = 6;

    // Output period in clock cycles for a rate code
    function automatic longint unsigned rate_period(input logic [2:0] code,
                                                    input longint unsigned hz);
        longint unsigned p;
        case (code)
            3'd0:    p = (hz * 4) / 3;
            3'd1:    p = (hz * 2) / 3;
            3'd2:    p = hz / 3;
            3'd3:    p = (hz * 2) / 15;
            3'd4:    p = hz / 15;
            3'd5:    p = hz / 30;
            3'd6:    p = hz / 75;
            default: p = hz / 220;
        endcase
        return (p == 0) ? 64'd1 : p;
    endfunction

endpackage

// File: rtl/magres_sched.sv
module magres_sched
    import magres_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int          TW     = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       md_wr,
    input  logic [1:0] md_val,
    input  logic       cfg_wr,
    input  logic [2:0] rate_code,
    input  logic       meas_done,
    output logic       meas_start,
    output logic       go_idle
);

    sched_st_e       st_q, st_d;
    logic [TW-1:0]   tmr_q;
    logic [TW-1:0]   ld_first, ld_next;
    longint unsigned per_c;
    logic            restart;

    always_comb begin
        per_c    = rate_period(rate_code, longint'(CLK_HZ));
        ld_first = TW'(2 * per_c - 1);
        ld_next  = TW'(per_c - 1);
    end

    assign restart = md_wr ? (md_val == MD_CONT) : (cfg_wr && st_q == SC_CONT);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_IDLE:     st_d = SC_IDLE;
            SC_ONE_GO:   st_d = SC_ONE_WAIT;
            SC_ONE_WAIT: if (meas_done) st_d = SC_IDLE;
            SC_CONT:     st_d = SC_CONT;
        endcase
        if (md_wr) begin
            unique case (md_val)
                MD_CONT: st_d = SC_CONT;
                MD_ONE:  st_d = SC_ONE_GO;
                default: st_d = SC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SC_ONE_GO;
        else        st_q <= st_d;
    end

    // period timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      tmr_q <= '0;
        else if (restart)                tmr_q <= ld_first;
        else if (st_q == SC_CONT) begin
            if (tmr_q == '0)             tmr_q <= ld_next;
            else                         tmr_q <= tmr_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        meas_start = (st_q == SC_ONE_GO) || (st_q == SC_CONT && tmr_q == '0);
        go_idle    = (st_q == SC_ONE_WAIT) && meas_done && !md_wr;
    end

endmodule

// File: rtl/magres_bank.sv
module magres_bank
    import magres_pkg::*;
#(
    parameter int HOLD = 2,
    parameter int HW   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        meas_done,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    input  logic [15:0] z_in,
    input  logic        rd_res,
    input  logic [2:0]  rd_idx,
    input  logic        rd_mode,
    input  logic        unlock,
    input  logic        meas_start,
    output logic [15:0] x_q,
    output logic [15:0] y_q,
    output logic [15:0] z_q,
    output logic        rdy,
    output logic        lock,
    output logic        dow,
    output logic        drdy_n
);

    localparam logic [NBYTES-1:0] ALL_READ = '1;

    post_st_e           pst_q, pst_d;
    logic [HW-1:0]      cnt_q, dr_cnt_q;
    logic [15:0]        sx_q, sy_q, sz_q;
    logic [NBYTES-1:0]  mask_q, mask_rd;
    logic               unread_q, accept, commit;

    assign accept  = (pst_q == PB_IDLE) && meas_done && !lock;
    assign commit  = (pst_q == PB_HOLD) && (cnt_q == '0);
    assign mask_rd = mask_q | (NBYTES'(1) << rd_idx);

    always_comb begin
        pst_d = pst_q;
        unique case (pst_q)
            PB_IDLE: if (accept) pst_d = PB_HOLD;
            PB_HOLD: if (commit) pst_d = PB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst_q <= PB_IDLE;
        else        pst_q <= pst_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; dr_cnt_q <= '0;
            sx_q <= '0; sy_q <= '0; sz_q <= '0;
            x_q <= '0;  y_q <= '0;  z_q <= '0;
            mask_q <= '0; unread_q <= 1'b0;
            rdy <= 1'b0; lock <= 1'b0; dow <= 1'b0;
        end else begin
            if (accept) begin
                sx_q <= x_in; sy_q <= y_in; sz_q <= z_in;
                cnt_q <= HW'(HOLD - 1);
                rdy   <= 1'b0;
            end else if (pst_q == PB_HOLD && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (commit) begin
                x_q <= sx_q; y_q <= sy_q; z_q <= sz_q;
                rdy      <= 1'b1;
                dow      <= unread_q;
                unread_q <= 1'b1;
                mask_q   <= '0;
            end else if (unlock) begin
                mask_q <= '0;
            end else if (rd_res) begin
                mask_q <= mask_rd;
                dow    <= 1'b0;
                if (mask_rd == ALL_READ) unread_q <= 1'b0;
            end

            if (commit)              dr_cnt_q <= HW'(HOLD);
            else if (dr_cnt_q != '0) dr_cnt_q <= dr_cnt_q - 1'b1;

            if (unlock || (meas_start && mask_q == ALL_READ)) lock <= 1'b0;
            else if (rd_res || rd_mode)                         lock <= 1'b1;
        end
    end

    assign drdy_n = (dr_cnt_q == '0);

    // low-time trackers used by the width checks
    logic [HW-1:0] rdy_lo, dr_lo;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_lo <= HW'(HOLD);
            dr_lo  <= '0;
        end else begin
            if (rdy)                      rdy_lo <= '0;
            else if (rdy_lo != HW'(HOLD)) rdy_lo <= rdy_lo + 1'b1;
            if (drdy_n)                   dr_lo  <= '0;
            else if (dr_lo != HW'(HOLD))  dr_lo  <= dr_lo + 1'b1;
        end
    end

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && pst_q == PB_IDLE) |=> $stable({x_q, y_q, z_q}));

    assert_rdy_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (rdy_lo >= HW'(HOLD)));

    assert_drdy_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_n) |-> (dr_lo >= HW'(HOLD)));

    assert_drdy_with_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> rdy);

endmodule

// File: rtl/magres_ctrl.sv
module magres_ctrl
    import magres_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        ptr_load,
    input  logic [7:0]  ptr_val,
    input  logic        rd_ack,
    output logic [7:0]  rd_data,
    output logic [7:0]  reg_ptr,
    output logic        meas_start,
    input  logic        meas_done,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    input  logic [15:0] z_in,
    output logic        drdy_n,
    output logic [7:0]  cfg_a,
    output logic [7:0]  mode_r,
    output logic [2:0]  rate_eff,
    output logic [1:0]  avg_eff
);

    localparam int              HOLD = CLK_HZ / 5000 + 1;
    localparam int              HW   = $clog2(HOLD + 1);
    localparam longint unsigned PMAX = (longint'(CLK_HZ) * 4) / 3;
    localparam int              TW   = $clog2(2 * PMAX + 1);

    logic [7:0]  cfg_q, cfg_d, mode_q, mode_d, ptr_q;
    logic        wr_cfg, wr_mode, go_idle;
    logic        rd_res, rd_mode, in_res;
    logic [2:0]  rd_idx, rate_nxt;
    logic [15:0] x_q, y_q, z_q;
    logic        rdy, lock, dow;

    assign wr_cfg  = wr_en && (wr_addr == A_CFG);
    assign wr_mode = wr_en && (wr_addr == A_MODE);

    always_comb begin
        cfg_d  = wr_cfg ? wr_data : cfg_q;
        mode_d = mode_q;
        if (wr_mode)      mode_d = wr_data & MODE_WMASK;
        else if (go_idle) mode_d = {mode_q[7:2], MD_IDLE};
        rate_nxt = mode_d[LP_BIT] ? 3'd0 : cfg_d[4:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            mode_q <= MODE_RST;
            ptr_q  <= '0;
        end else begin
            cfg_q  <= cfg_d;
            mode_q <= mode_d;
            if (ptr_load)    ptr_q <= ptr_val;
            else if (rd_ack) ptr_q <= (ptr_q == A_RES_HI) ? A_RES_LO : ptr_q + 8'd1;
        end
    end

    assign in_res  = (ptr_q >= A_RES_LO) && (ptr_q <= A_RES_HI);
    assign rd_res  = rd_ack && !ptr_load && in_res;
    assign rd_mode = rd_ack && !ptr_load && (ptr_q == A_MODE);
    assign rd_idx  = 3'(ptr_q - A_RES_LO);

    magres_sched #(.CLK_HZ(CLK_HZ), .TW(TW)) sched_i (
        .clk(clk), .rst_n(rst_n),
        .md_wr(wr_mode), .md_val(wr_data[1:0]), .cfg_wr(wr_cfg),
        .rate_code(rate_nxt), .meas_done(meas_done),
        .meas_start(meas_start), .go_idle(go_idle)
    );

    magres_bank #(.HOLD(HOLD), .HW(HW)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .meas_done(meas_done), .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .rd_res(rd_res), .rd_idx(rd_idx), .rd_mode(rd_mode),
        .unlock(wr_cfg || wr_mode), .meas_start(meas_start),
        .x_q(x_q), .y_q(y_q), .z_q(z_q),
        .rdy(rdy), .lock(lock), .dow(dow), .drdy_n(drdy_n)
    );

    always_comb begin
        unique case (ptr_q)
            A_CFG:   rd_data = cfg_q;
            A_MODE:  rd_data = mode_q;
            8'h03:   rd_data = x_q[15:8];
            8'h04:   rd_data = x_q[7:0];
            8'h05:   rd_data = z_q[15:8];
            8'h06:   rd_data = z_q[7:0];
            8'h07:   rd_data = y_q[15:8];
            8'h08:   rd_data = y_q[7:0];
            A_STAT:  rd_data = {5'd0, dow, lock, rdy};
            default: rd_data = 8'h00;
        endcase
    end

    assign reg_ptr  = ptr_q;
    assign cfg_a    = cfg_q;
    assign mode_r   = mode_q;
    assign rate_eff = mode_q[LP_BIT] ? 3'd0 : cfg_q[4:2];
    assign avg_eff  = mode_q[LP_BIT] ? 2'd0 : cfg_q[6:5];

    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !ptr_load && ptr_q == A_RES_HI) |=> (ptr_q == A_RES_LO));

    assert_one_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go_idle |=> (mode_q[1:0] == MD_IDLE));

    assert_mode_undef_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (mode_q[6] == 1'b0 && mode_q[4] == 1'b0 && mode_q[3] == 1'b0));

endmodule

// File: tb/magres_ctrl_tb_top.sv
module magres_ctrl_tb_top;

    localparam int unsigned CLK_HZ = 22000;
    localparam int HOLD_E = CLK_HZ / 5000 + 1;  // 5
    localparam int P7     = CLK_HZ / 220;       // 100

    // expected byte stream while walking the result bytes (last entry: wrap)
    localparam logic [7:0] WALK_EXP [7] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'h12};

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, ptr_load = 0, rd_ack = 0, meas_done = 0;
    logic [7:0]  wr_addr = 0, wr_data = 0, ptr_val = 0;
    logic [15:0] x_in = 0, y_in = 0, z_in = 0;
    logic [7:0]  rd_data, reg_ptr, cfg_a, mode_r;
    logic        meas_start, drdy_n;
    logic [2:0]  rate_eff;
    logic [1:0]  avg_eff;

    int checks = 0, fails = 0;
    int cyc = 0, starts = 0, last_st = 0, last_wr = 0, dr_falls = 0;
    logic dr_prev = 1;
    bit   done_flag = 0;

    always #4 clk = ~clk;

    magres_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_ack(rd_ack), .rd_data(rd_data),
        .reg_ptr(reg_ptr), .meas_start(meas_start), .meas_done(meas_done),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .drdy_n(drdy_n), .cfg_a(cfg_a),
        .mode_r(mode_r), .rate_eff(rate_eff), .avg_eff(avg_eff)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && meas_start) begin starts <= starts + 1; last_st <= cyc; end
        if (wr_en) last_wr <= cyc;
        dr_prev <= drdy_n;
        if (rst_n && dr_prev && !drdy_n) dr_falls <= dr_falls + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); ptr_load = 1; ptr_val = a;
        @(negedge clk); ptr_load = 0; d = rd_data;
    endtask

    task automatic ack();
        rd_ack = 1; @(negedge clk); rd_ack = 0;
    endtask

    task automatic post(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        @(negedge clk); meas_done = 1; x_in = x; y_in = y; z_in = z;
        @(negedge clk); meas_done = 0;
    endtask

    task automatic settle();
        repeat (HOLD_E + 2) @(negedge clk);
    endtask

    task automatic wait_starts(input int n);
        while (starts < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-chain: run did not finish actual=hung expected=done");
        if (!done_flag) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lowc, s0, st1, sN;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state (pointer 0 shows cfg register)
        check("R1 ptr", reg_ptr, 0);
        check("R1 cfg", rd_data, 8'h10);
        check("R1 drdy_n", drdy_n, 1);
        @(negedge clk);
        check("R1 one start", starts, 1);
        peek(8'h02, d); check("R1 mode", d, 8'h01);
        peek(8'h09, d); check("R1 status", d, 8'h00);

        // R6 / R7: first result posting, pointer parked on status
        post(16'h1234, 16'h9ABC, 16'h5678);
        repeat (HOLD_E - 1) @(negedge clk);
        check("R6 ready held low", rd_data, 8'h00);
        check("R7 drdy before commit", drdy_n, 1);
        @(negedge clk);
        check("R6 ready set", rd_data, 8'h01);
        check("R7 drdy low", drdy_n, 0);
        lowc = 1;
        forever begin @(negedge clk); if (drdy_n) break; lowc++; end
        check("R7 drdy width", lowc, HOLD_E);
        peek(8'h02, d); check("R9 mode back to idle", d, 8'h02);

        // R2 / R3: table walk over result bytes with wrap
        peek(8'h03, d);
        for (int i = 0; i < 7; i++) begin
            check($sformatf("R2 R3 walk %0d", i), rd_data, WALK_EXP[i]);
            if (i < 6) ack();
        end
        check("R3 ptr wrapped", reg_ptr, 8'h03);
        peek(8'h09, d); check("R4 lock after reads", d, 8'h03);

        // R4: locked result discarded
        s0 = dr_falls;
        post(16'hAAAA, 16'hBBBB, 16'hCCCC);
        settle();
        check("R4 status unchanged", rd_data, 8'h03);
        peek(8'h03, d); check("R4 bytes frozen", d, 8'h12);
        check("R4 no drdy pulse", dr_falls, s0);

        // R5 cfg write unlocks, R12 effective fields
        wr(8'h00, 8'h7C);
        peek(8'h09, d); check("R5 cfg write unlock", d, 8'h01);
        check("R12 rate follows", rate_eff, 7);
        check("R12 avg follows", avg_eff, 3);
        peek(8'h02, d); ack();
        peek(8'h09, d); check("R4 mode read locks", d, 8'h03);
        wr(8'h02, 8'hFA);
        peek(8'h02, d); check("R13 mode mask", d, 8'hA2);
        peek(8'h09, d); check("R5 mode write unlock", d, 8'h01);
        check("R12 lp rate", rate_eff, 0);
        check("R12 lp avg", avg_eff, 0);
        wr(8'h03, 8'hFF);
        peek(8'h03, d); check("R13 result read-only", d, 8'h12);
        wr(8'h02, 8'h02);
        check("R12 lp off", rate_eff, 7);

        // R8 overwritten
        post(16'h1111, 16'h2222, 16'h3333); settle();
        peek(8'h09, d); check("R8 clean post", d, 8'h01);
        post(16'h4444, 16'h5555, 16'h6666); settle();
        check("R8 overwritten set", rd_data, 8'h05);
        peek(8'h03, d); check("R8 newest data", d, 8'h44);
        ack();
        peek(8'h09, d); check("R8 cleared by read", d, 8'h03);

        // R10 continuous timing at 220 Hz code
        s0 = starts;
        wr(8'h00, 8'h1C);
        wr(8'h02, 8'h00);
        wait_starts(s0 + 1);
        check("R10 first start 2P", last_st - last_wr, 2 * P7);
        st1 = last_st;
        post(16'h0102, 16'h0304, 16'h0506); settle();
        peek(8'h09, d); check("R8 unread before post", d, 8'h05);
        peek(8'h03, d);
        for (int i = 0; i < 6; i++) ack();
        peek(8'h09, d); check("R4 all read still locked", d, 8'h03);
        check("R5 no start yet", starts, s0 + 1);
        wait_starts(s0 + 2);
        check("R10 period P", last_st - st1, P7);
        @(negedge clk);
        check("R5 start unlocks", rd_data, 8'h01);

        // R11 cfg write restarts the 2P wait
        repeat (30) @(negedge clk);
        wr(8'h00, 8'h1C);
        wait_starts(s0 + 3);
        check("R11 restart 2P", last_st - last_wr, 2 * P7);

        // R9 idle and single
        wr(8'h02, 8'h03);
        sN = starts;
        repeat (300) @(negedge clk);
        check("R9 idle no starts", starts, sN);
        wr(8'h02, 8'h01);
        repeat (3) @(negedge clk);
        check("R9 single one start", starts, sN + 1);
        peek(8'h02, d); check("R9 single busy", d, 8'h01);
        post(16'h0A0B, 16'h0C0D, 16'h0E0F);
        peek(8'h02, d); check("R9 single to idle", d, 8'h02);
        repeat (20) @(negedge clk);
        check("R9 only one start", starts, sN + 1);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule